// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a memory-mapped port of up to eight general-purpose pins. Software reaches it over a simple bus with a write strobe and a combinational read. For each pin the port keeps five bits: an output latch, a direction bit, a pull-up enable, a slew-control enable and a drive-strength select. From these bits the block produces the pad controls for each pin: output enable, output value and pull-up enable. The slew and drive bits are passed out as plain control bits.

Pin levels coming in from the pads pass through a two-stage synchronizer before software can read them. When software reads the data register, each bit depends on that pin's direction. An output pin returns the value software wrote. An input pin returns the sampled level on the pad.

When the port is built, each pin position can be set as configurable, fixed output, fixed input or absent. The default build is a six-pin port with these positions:

- pin 4 is a fixed output;
- pin 5 is a fixed input;
- pins 6 and 7 are absent.

Top module: `gpio_port`

## Requirements
- R1: Writing the direction register (address 1) sets, for each configurable pin, output enable to the written bit (1 = output, 0 = input), and the new value appears on `pad_oe` one clock after the write.
- R2: A read of the data register (address 0) returns, for each present pin that is an input, the `pad_in` level after two rising clock edges, and not after only one.
- R3: A read of the data register returns, for each pin that is an output, the latched output bit rather than the pad level.
- R4: A read of the direction register returns the effective direction of every pin, including pins whose direction is fixed.
- R5: `pad_pu` is 1 for a pin only when its pull-up enable (address 4) is set, the pin is present and the pin is an input; an output pin never has its pull-up enabled.
- R6: In the default build, pin 4 is always an output and pin 5 is always an input, whatever is written to the direction register.
- R7: Absent pins (6 and 7 in the default build) read 0 in every register and drive 0 on every output, and writes to them are ignored.
- R8: Synchronous reset clears the data, direction, pull-up, slew and drive registers, so all configurable pins become inputs and `pad_out`, `pad_pu`, `pad_slew` and `pad_drive` are 0.
- R9: A write to the data register updates the output latch even while the pin is an input, so `pad_out` carries the preset level one clock later, before the pin is switched to output.
- R10: The slew register (address 5) and the drive register (address 6) read back what was written for present pins and appear on `pad_slew` and `pad_drive`.
- R11: Addresses 2, 3 and 7 read as 0, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS | Levels sampled from the pads |
| pad_oe | output | NPINS | Output enable per pin |
| pad_out | output | NPINS | Output value per pin |
| pad_pu | output | NPINS | Pull-up enable per pin |
| pad_slew | output | NPINS | Slew-control enable per pin |
| pad_drive | output | NPINS | Drive-strength select per pin |

## Verification
A register bit stored in the wrong place can be seen at the pad controls one clock after the write. It shows on `pad_oe`, `pad_out` or `pad_pu`, or when the same address is read back. The direction-dependent read is harder to observe. A wrong direction term or a wrong synchronizer depth shows only when the data register is read while the pad level and the latch disagree. The synchronizer depth also needs a read taken exactly one and exactly two edges after the pad changes. The stimulus therefore puts unlike patterns on the pads and in the latch. A pull-up left enabled on an output pin would show at once as `pad_pu` and `pad_oe` both high.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA  = 3'd0,
        REG_DIR   = 3'd1,
        REG_PULL  = 3'd4,
        REG_SLEW  = 3'd5,
        REG_DRIVE = 3'd6
    } gpio_reg_e;

    // per-pin register contents
    typedef struct packed {
        logic data;
        logic dir;
        logic pull;
        logic slew;
        logic drive;
    } pin_bits_t;

    // pad-side controls produced for one pin
    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
        logic slew;
        logic drive;
    } pad_ctl_t;

    function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
        return (a == REG_DATA) || (a == REG_DIR) || (a == REG_PULL) ||
               (a == REG_SLEW) || (a == REG_DRIVE);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int               NPINS    = 8,
    parameter logic [NPINS-1:0] PRESENT  = 8'h3F,
    parameter logic [NPINS-1:0] IN_ONLY  = 8'h20,
    parameter logic [NPINS-1:0] OUT_ONLY = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output pin_bits_t         regs [NPINS]
);
    localparam logic [NPINS-1:0] CFG_MASK = PRESENT & ~IN_ONLY & ~OUT_ONLY;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        if (PRESENT[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[i] <= '0;
                end else if (wr) begin
                    case (addr)
                        REG_DATA:  regs[i].data  <= wdata[i];
                        REG_DIR:   regs[i].dir   <= wdata[i] & CFG_MASK[i];
                        REG_PULL:  regs[i].pull  <= wdata[i];
                        REG_SLEW:  regs[i].slew  <= wdata[i];
                        REG_DRIVE: regs[i].drive <= wdata[i];
                        default: ;
                    endcase
                end
            end
        end else begin : g_absent
            assign regs[i] = '0;
        end
    end
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
    import gpio_pkg::*;
#(
    parameter bit PRESENT  = 1'b1,
    parameter bit IN_ONLY  = 1'b0,
    parameter bit OUT_ONLY = 1'b0
) (
    input  pin_bits_t r,
    input  logic      sync_in,
    output pad_ctl_t  ctl,
    output logic      rd_data
);
    logic is_out;

    always_comb begin
        if (!PRESENT)      is_out = 1'b0;
        else if (OUT_ONLY) is_out = 1'b1;
        else if (IN_ONLY)  is_out = 1'b0;
        else               is_out = r.dir;
    end

    always_comb begin
        ctl.oe    = is_out;
        ctl.out   = PRESENT & r.data;
        ctl.pu    = PRESENT & r.pull & ~is_out;
        ctl.slew  = PRESENT & r.slew;
        ctl.drive = PRESENT & r.drive;
        rd_data   = PRESENT & (is_out ? r.data : sync_in);
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int               NPINS    = 8,
    parameter logic [NPINS-1:0] PRESENT  = 8'h3F,
    parameter logic [NPINS-1:0] IN_ONLY  = 8'h20,
    parameter logic [NPINS-1:0] OUT_ONLY = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_slew,
    output logic [NPINS-1:0]  pad_drive
);
    pin_bits_t        regs [NPINS];
    logic [NPINS-1:0] sync_in;
    logic [NPINS-1:0] rd_data_vec;
    logic [NPINS-1:0] pull_vec;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_in)
    );

    gpio_regfile #(
        .NPINS(NPINS), .PRESENT(PRESENT), .IN_ONLY(IN_ONLY), .OUT_ONLY(OUT_ONLY)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .regs  (regs)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pad_ctl_t ctl;

        gpio_pin #(
            .PRESENT(PRESENT[i]), .IN_ONLY(IN_ONLY[i]), .OUT_ONLY(OUT_ONLY[i])
        ) u_pin (
            .r       (regs[i]),
            .sync_in (sync_in[i]),
            .ctl     (ctl),
            .rd_data (rd_data_vec[i])
        );

        assign pad_oe[i]    = ctl.oe;
        assign pad_out[i]   = ctl.out;
        assign pad_pu[i]    = ctl.pu;
        assign pad_slew[i]  = ctl.slew;
        assign pad_drive[i] = ctl.drive;
        assign pull_vec[i]  = regs[i].pull;
    end

    always_comb begin
        case (bus_addr)
            REG_DATA:  bus_rdata = rd_data_vec;
            REG_DIR:   bus_rdata = pad_oe;
            REG_PULL:  bus_rdata = pull_vec;
            REG_SLEW:  bus_rdata = pad_slew;
            REG_DRIVE: bus_rdata = pad_drive;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker
    import gpio_pkg::*;
#(
    parameter int               NPINS    = 8,
    parameter logic [NPINS-1:0] PRESENT  = 8'h3F,
    parameter logic [NPINS-1:0] IN_ONLY  = 8'h20,
    parameter logic [NPINS-1:0] OUT_ONLY = 8'h10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_pu,
    input logic [NPINS-1:0]  pad_slew,
    input logic [NPINS-1:0]  pad_drive
);
    localparam logic [NPINS-1:0] CFG_MASK = PRESENT & ~IN_ONLY & ~OUT_ONLY;

    p_dir_write_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_DIR) |=>
            pad_oe == (($past(bus_wdata) & CFG_MASK) | OUT_ONLY));

    p_pull_off_on_output_r5: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0);

    p_fixed_dir_r6: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & OUT_ONLY) == OUT_ONLY) && ((pad_oe & IN_ONLY) == '0));

    p_absent_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe | pad_out | pad_pu | pad_slew | pad_drive | bus_rdata) & ~PRESENT) == '0);

    p_preset_latch_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_DATA) |=> pad_out == ($past(bus_wdata) & PRESENT));

    p_unmapped_read_r11: assert property (@(posedge clk) disable iff (rst)
        !addr_mapped(bus_addr) |-> bus_rdata == '0);

    p_unmapped_write_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !addr_mapped(bus_addr)) |=>
            $stable(pad_oe) && $stable(pad_out) && $stable(pad_pu) &&
            $stable(pad_slew) && $stable(pad_drive));
endmodule

bind gpio_port gpio_port_checker #(
    .NPINS(NPINS), .PRESENT(PRESENT), .IN_ONLY(IN_ONLY), .OUT_ONLY(OUT_ONLY)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu),
    .pad_slew  (pad_slew),
    .pad_drive (pad_drive)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pu, pad_slew, pad_drive;

    int n_checks = 0;
    int n_bad    = 0;

    always #2 clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .pad_slew(pad_slew), .pad_drive(pad_drive)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // fields: wr, waddr, wdata, pin, raddr, rdata, oe, out, pu
    localparam int NV = 10;
    localparam logic [54:0] VEC [NV] = '{
        {1'b1, 3'd4, 8'hFF, 8'hA5, 3'd0, 8'h25, 8'h10, 8'h00, 8'h2F}, // R2 R5 inputs, pulls
        {1'b1, 3'd0, 8'hFF, 8'h00, 3'd0, 8'h10, 8'h10, 8'h3F, 8'h2F}, // R9 preset latch
        {1'b1, 3'd1, 8'h0F, 8'h00, 3'd1, 8'h1F, 8'h1F, 8'h3F, 8'h20}, // R1 R4 R5
        {1'b1, 3'd0, 8'h5A, 8'hFF, 3'd0, 8'h3A, 8'h1F, 8'h1A, 8'h20}, // R3 latch on outputs
        {1'b1, 3'd1, 8'hFF, 8'hFF, 3'd1, 8'h1F, 8'h1F, 8'h1A, 8'h20}, // R6 R7 fixed/absent
        {1'b1, 3'd1, 8'h00, 8'hC3, 3'd0, 8'h13, 8'h10, 8'h1A, 8'h2F}, // R2 R6 mixed read
        {1'b1, 3'd5, 8'hFF, 8'h00, 3'd5, 8'h3F, 8'h10, 8'h1A, 8'h2F}, // R10 R7 slew
        {1'b1, 3'd7, 8'hFF, 8'h00, 3'd6, 8'h00, 8'h10, 8'h1A, 8'h2F}, // R11 unmapped write
        {1'b0, 3'd0, 8'h00, 8'h00, 3'd3, 8'h00, 8'h10, 8'h1A, 8'h2F}, // R11 unmapped read
        {1'b1, 3'd6, 8'hC1, 8'h00, 3'd6, 8'h01, 8'h10, 8'h1A, 8'h2F}  // R10 R7 drive
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        #1;
        chk("R8 oe", pad_oe, 8'h10);
        chk("R8 out", pad_out, 8'h00);
        chk("R8 pu", pad_pu, 8'h00);
        chk("R8 slew", pad_slew, 8'h00);
        chk("R8 drive", pad_drive, 8'h00);
        bus_addr = 3'd1; #1;
        chk("R8 dir read", bus_rdata, 8'h10);
        bus_addr = 3'd4; #1;
        chk("R8 pull read", bus_rdata, 8'h00);

        // R2 two-stage sampling depth
        @(negedge clk);
        bus_addr = 3'd0;
        pad_in   = 8'h01;
        @(posedge clk);
        @(negedge clk); #1;
        chk("R2 one edge", bus_rdata, 8'h00);
        @(posedge clk);
        @(negedge clk); #1;
        chk("R2 two edges", bus_rdata, 8'h01);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            bus_wr    = VEC[k][54];
            bus_addr  = VEC[k][53:51];
            bus_wdata = VEC[k][50:43];
            pad_in    = VEC[k][42:35];
            @(posedge clk);
            @(negedge clk);
            bus_wr = 1'b0;
            repeat (2) @(posedge clk);
            @(negedge clk);
            bus_addr = VEC[k][34:32];
            #1;
            chk($sformatf("R1-table row%0d rdata", k), bus_rdata, VEC[k][31:24]);
            chk($sformatf("R6 row%0d oe", k), pad_oe, VEC[k][23:16]);
            chk($sformatf("R9 row%0d out", k), pad_out, VEC[k][15:8]);
            chk($sformatf("R5 row%0d pu", k), pad_pu, VEC[k][7:0]);
        end

        // R10 exported slew and drive, R7 absent bits zero
        chk("R10 slew out", pad_slew, 8'h3F);
        chk("R10 drive out", pad_drive, 8'h01);
        bus_addr = 3'd4; #1;
        chk("R7 pull read masks absent", bus_rdata, 8'h3F);

        // R8 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        pad_in = 8'h00;
        #1;
        chk("R8 oe after reset", pad_oe, 8'h10);
        chk("R8 out after reset", pad_out, 8'h00);
        chk("R8 pu after reset", pad_pu, 8'h00);
        chk("R8 slew after reset", pad_slew, 8'h00);
        chk("R8 drive after reset", pad_drive, 8'h00);
        bus_addr = 3'd1; #1;
        chk("R8 dir read after reset", bus_rdata, 8'h10);

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule